// File: doc/BRIEF.md
# Selectable-Phase Receive Word Retimer

This block carries a word and its valid flag out of a recovered receive clock and into the system clock. Both clocks run at the same frequency, and the phase between them is fixed but can take any value over a whole period. The incoming word is first held in a register clocked by the receive clock. Two transfer paths then run side by side into the system domain. The direct path samples the held word on the rising system edge. The indirect path samples it on the falling system edge and moves it to a rising-edge register one half period later.

Software measures or sweeps the link once and sets a single select input. That input picks the path whose sampling instant sits clear of the receive register's switching moment. A final rising-edge stage applies the choice, so both paths present their results at the same output timing. After a change of the select input, that stage withholds valid for one cycle. There is no rate matching and no automatic phase search.

Top module: `rx_phase_retimer`

## Requirements
- R1: On each rising receive-clock edge with the receive reset released, the receive register loads the receive word and its valid flag. While the receive reset is asserted, it holds zero data and valid low.
- R2: With the select input at 0 (direct path) at two consecutive rising system edges n-1 and n, the output after edge n carries the word and valid that the receive register held just before edge n-1.
- R3: With the select input at 1 (indirect path) at two consecutive rising system edges n-1 and n, the output after edge n carries the word and valid that the receive register held just before the falling system edge between edges n-2 and n-1.
- R4: Valid travels through the same registers as its data. The output valid after edge n is the valid flag captured with the word shown on the data output.
- R5: At the first rising system edge where the select input differs from its value at the previous edge, the output valid is forced low. The output data at that edge still comes from the newly selected path.
- R6: While the system reset is asserted, the outputs are zero data with valid low. After release, the first rising edge still yields valid low, because both paths were cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rx_clk | input | 1 | Recovered receive clock |
| rx_rst_n | input | 1 | Active-low asynchronous reset, receive domain |
| rx_data | input | DATA_W | Received word |
| rx_valid | input | 1 | Received word is meaningful |
| sys_clk | input | 1 | System clock, same frequency as rx_clk |
| sys_rst_n | input | 1 | Active-low asynchronous reset, system domain |
| path_sel | input | 1 | 0 = direct rising-edge path, 1 = falling-edge intermediate path |
| out_data | output | DATA_W | Retimed word in the system domain |
| out_valid | output | 1 | Retimed valid flag |

## Verification
The bench sweeps the receive clock phase over eight offsets spread across the whole period, on either side of the half-period point. It runs each offset with the direct path fixed, with the indirect path fixed, and with the select input toggling. The first two runs separate the two latencies. Above half a period, the indirect path lags by a full extra cycle. A design that sampled the intermediate register on the wrong edge, or that drew both paths from one register, would show a word off by one cycle at exactly those offsets.

A gap pattern in the receive valid flag exposes a valid that is not pipelined with its data. The toggling run catches an output stage that fails to blank the switch cycle, or that blanks the wrong cycle. The reset checks catch paths that are not cleared, which would leak stale words in the first cycles after release.

// File: rtl/rt_pkg.sv
`timescale 1ns/1ps
package rt_pkg;
    typedef enum logic {
        PATH_DIRECT   = 1'b0,
        PATH_INDIRECT = 1'b1
    } path_e;
endpackage

// File: rtl/rt_rx_capture.sv
`timescale 1ns/1ps
// Receive-domain holding register for {valid, data}.
module rt_rx_capture #(
    parameter int WORD_W = 17
) (
    input  logic              rx_clk,
    input  logic              rx_rst_n,
    input  logic [WORD_W-1:0] in_word,
    output logic [WORD_W-1:0] cap_word
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.word = in_word;
    end

    always_ff @(posedge rx_clk or negedge rx_rst_n) begin
        if (!rx_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_word = st_q.word;
endmodule

// File: rtl/rt_direct_stage.sv
`timescale 1ns/1ps
// Direct transfer: receive register sampled on the rising system edge.
module rt_direct_stage #(
    parameter int WORD_W = 17
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic [WORD_W-1:0] src_word,
    output logic [WORD_W-1:0] dir_word
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
    } dir_st_t;

    dir_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.word = src_word;
    end

    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_word = st_q.word;
endmodule

// File: rtl/rt_indirect_stage.sv
`timescale 1ns/1ps
// Indirect transfer: falling-edge intermediate register, then a
// rising-edge register, half a period later than the direct sample point.
module rt_indirect_stage #(
    parameter int WORD_W = 17
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic [WORD_W-1:0] src_word,
    output logic [WORD_W-1:0] ind_word
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
    } mid_st_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
    } ind_st_t;

    mid_st_t mid_d, mid_q;
    ind_st_t ind_d, ind_q;

    always_comb begin
        mid_d      = mid_q;
        mid_d.word = src_word;
        ind_d      = ind_q;
        ind_d.word = mid_q.word;
    end

    always_ff @(negedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            mid_q <= '0;
        end else begin
            mid_q <= mid_d;
        end
    end

    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            ind_q <= '0;
        end else begin
            ind_q <= ind_d;
        end
    end

    assign ind_word = ind_q.word;
endmodule

// File: rtl/rt_out_select.sv
`timescale 1ns/1ps
// Output stage: picks a path and blanks valid on the cycle the choice changes.
module rt_out_select
    import rt_pkg::*;
#(
    parameter int WORD_W = 17
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  path_e             sel,
    input  logic [WORD_W-1:0] dir_word,
    input  logic [WORD_W-1:0] ind_word,
    output logic [WORD_W-1:0] out_word
);
    localparam int VALID_BIT = WORD_W - 1;

    typedef struct packed {
        path_e             sel;
        logic [WORD_W-1:0] word;
    } out_st_t;

    out_st_t           st_d, st_q;
    logic [WORD_W-1:0] chosen;
    logic              sel_steady;

    always_comb begin
        chosen     = (sel == PATH_INDIRECT) ? ind_word : dir_word;
        sel_steady = (sel == st_q.sel);
        st_d       = st_q;
        st_d.sel   = sel;
        st_d.word  = chosen;
        st_d.word[VALID_BIT] = chosen[VALID_BIT] & sel_steady;
    end

    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            st_q <= '{sel: PATH_DIRECT, word: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_word = st_q.word;
endmodule

// File: rtl/rx_phase_retimer.sv
`timescale 1ns/1ps
module rx_phase_retimer
    import rt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              rx_clk,
    input  logic              rx_rst_n,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              path_sel,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);
    localparam int WORD_W = DATA_W + 1;

    logic [WORD_W-1:0] cap_word;
    logic [WORD_W-1:0] dir_word;
    logic [WORD_W-1:0] ind_word;
    logic [WORD_W-1:0] out_word;
    path_e             sel_path;

    assign sel_path = path_e'(path_sel);

    rt_rx_capture #(.WORD_W(WORD_W)) u_capture (
        .rx_clk   (rx_clk),
        .rx_rst_n (rx_rst_n),
        .in_word  ({rx_valid, rx_data}),
        .cap_word (cap_word)
    );

    rt_direct_stage #(.WORD_W(WORD_W)) u_direct (
        .sys_clk   (sys_clk),
        .sys_rst_n (sys_rst_n),
        .src_word  (cap_word),
        .dir_word  (dir_word)
    );

    rt_indirect_stage #(.WORD_W(WORD_W)) u_indirect (
        .sys_clk   (sys_clk),
        .sys_rst_n (sys_rst_n),
        .src_word  (cap_word),
        .ind_word  (ind_word)
    );

    rt_out_select #(.WORD_W(WORD_W)) u_select (
        .sys_clk   (sys_clk),
        .sys_rst_n (sys_rst_n),
        .sel       (sel_path),
        .dir_word  (dir_word),
        .ind_word  (ind_word),
        .out_word  (out_word)
    );

    assign out_valid = out_word[WORD_W-1];
    assign out_data  = out_word[DATA_W-1:0];
endmodule

// File: rtl/rt_retimer_checker.sv
`timescale 1ns/1ps
module rt_retimer_checker #(
    parameter int WORD_W = 17
) (
    input logic              rx_clk,
    input logic              rx_rst_n,
    input logic              sys_clk,
    input logic              sys_rst_n,
    input logic              path_sel,
    input logic [WORD_W-1:0] rx_word,
    input logic [WORD_W-1:0] cap_word,
    input logic [WORD_W-1:0] dir_word,
    input logic [WORD_W-1:0] ind_word,
    input logic [WORD_W-1:0] out_word
);
    localparam int VB = WORD_W - 1;

    AST_CAPTURE_LOADS: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        rx_rst_n |=> cap_word == $past(rx_word)); // R1

    AST_DIRECT_SOURCE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (!path_sel && !$past(path_sel) && $past(sys_rst_n)) |=> out_word == $past(dir_word)); // R2

    AST_INDIRECT_SOURCE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (path_sel && $past(path_sel) && $past(sys_rst_n)) |=> out_word == $past(ind_word)); // R3

    AST_VALID_FROM_PATH: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        $rose(out_word[VB]) |-> $past(path_sel ? ind_word[VB] : dir_word[VB])); // R4

    AST_SWITCH_BLANKS: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (path_sel != $past(path_sel)) |=> !out_word[VB]); // R5

    AST_RESET_QUIET: assert property (@(posedge sys_clk)
        !sys_rst_n |-> (out_word == '0)); // R6
endmodule

bind rx_phase_retimer rt_retimer_checker #(.WORD_W(DATA_W + 1)) u_checker (
    .rx_clk    (rx_clk),
    .rx_rst_n  (rx_rst_n),
    .sys_clk   (sys_clk),
    .sys_rst_n (sys_rst_n),
    .path_sel  (path_sel),
    .rx_word   ({rx_valid, rx_data}),
    .cap_word  (cap_word),
    .dir_word  (dir_word),
    .ind_word  (ind_word),
    .out_word  (out_word)
);

// File: tb/test_rx_phase_retimer.sv
`timescale 1ns/1ps
module test_rx_phase_retimer;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int DW         = 16;
    localparam int RUN        = 60;
    localparam int HIST       = 128;

    logic          sys_clk   = 1'b0;
    logic          rx_clk    = 1'b0;
    logic          sys_rst_n = 1'b0;
    logic          rx_rst_n  = 1'b0;
    logic          path_sel  = 1'b0;
    logic [DW-1:0] rx_data   = '0;
    logic          rx_valid  = 1'b0;
    logic [DW-1:0] out_data;
    logic          out_valid;

    int   off = 1;
    int   rx_cnt = 0;
    int   n = 0;
    int   rise_cnt [HIST];
    int   fall_cnt [HIST];
    logic sel_rise [HIST];
    int   vectors = 0;
    int   miscompares = 0;
    bit   done = 1'b0;

    rx_phase_retimer #(.DATA_W(DW)) i_rx_phase_retimer (
        .rx_clk    (rx_clk),
        .rx_rst_n  (rx_rst_n),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .sys_clk   (sys_clk),
        .sys_rst_n (sys_rst_n),
        .path_sel  (path_sel),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    function automatic logic [DW-1:0] pat(int idx);
        logic [31:0] t;
        t = 32'(idx) * 32'd40503 + 32'd11;
        return t[DW-1:0];
    endfunction

    function automatic logic vpat(int idx);
        return (idx % 5) != 2;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    // clocks: rx_clk follows sys_clk by 'off' ns
    always #(HALF) sys_clk = ~sys_clk;
    always begin @(posedge sys_clk); #(off); rx_clk = 1'b1; end
    always begin @(negedge sys_clk); #(off); rx_clk = 1'b0; end

    // receive side: word k is presented before receive rise k+1
    always @(posedge rx_clk) begin
        if (!rx_rst_n) rx_cnt <= 0;
        else           rx_cnt <= rx_cnt + 1;
    end
    always @(negedge rx_clk) begin
        rx_data  <= pat(rx_cnt);
        rx_valid <= vpat(rx_cnt);
    end

    // bookkeeping of edge timing
    initial sel_rise[0] = 1'b0;
    always @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            n = 0;
        end else begin
            n = n + 1;
            if (n < HIST) begin
                rise_cnt[n] = rx_cnt;
                sel_rise[n] = path_sel;
            end
        end
    end

    always @(negedge sys_clk) begin
        if (sys_rst_n && n < HIST) begin
            fall_cnt[n] = rx_cnt;
            if (n >= 1) begin
                int            k;
                logic          sw;
                logic [DW-1:0] e_data;
                logic          e_valid;
                if (sel_rise[n] == 1'b0) k = (n >= 2) ? rise_cnt[n-1] : 0;  // R2
                else                     k = (n >= 2) ? fall_cnt[n-2] : 0;  // R3
                sw      = (sel_rise[n] != sel_rise[n-1]);                   // R5
                e_data  = (k > 0) ? pat(k-1) : '0;                          // R1
                e_valid = (k > 0) ? (vpat(k-1) && !sw) : 1'b0;              // R4
                vectors++;
                if (out_data !== e_data) begin
                    miscompares++;
                    $display("FAIL %s data off=%0d n=%0d actual=%h expected=%h",
                             sel_rise[n] ? "R3" : "R2", off, n, out_data, e_data);
                end
                vectors++;
                if (out_valid !== e_valid) begin
                    miscompares++;
                    $display("FAIL %s valid off=%0d n=%0d actual=%b expected=%b",
                             sw ? "R5" : "R4", off, n, out_valid, e_valid);
                end
            end
        end
    end

    initial begin
        for (int mode = 0; mode < 3; mode++) begin
            for (int oi = 0; oi < 8; oi++) begin
                sys_rst_n = 1'b0;
                rx_rst_n  = 1'b0;
                off       = (oi < 4) ? oi + 1 : oi + 2;
                path_sel  = (mode == 1);
                repeat (4) @(negedge sys_clk);
                vectors++;
                if (out_valid !== 1'b0 || out_data !== '0) begin
                    miscompares++;
                    $display("FAIL R6 reset outputs actual=%b/%h expected=0/0000",
                             out_valid, out_data);
                end
                @(posedge sys_clk);
                #2 sys_rst_n = 1'b1;
                @(negedge rx_clk);
                rx_rst_n = 1'b1;
                for (int c = 0; c < RUN; c++) begin
                    @(negedge sys_clk);
                    if (mode == 2 && (n % 9) == 4) path_sel = ~path_sel;
                end
            end
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            miscompares++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule